// File: doc/BRIEF.md
# Oversampling Clock and Data Recovery

This block recovers a bit clock and retimed data from a serial input that is sampled many times per bit by a fast local clock. A phase counter runs once per bit period. Each transition on the input nudges that counter toward putting the sampling instant in the middle of the bit. An integral term trims the counter's period, within a window set around a programmed nominal number of samples per bit. At the middle of every recovered bit the block captures the input and pulses a one-cycle strobe.

A control field sets how far the recovered period may drift from nominal. Another field sets how many silent bit times are allowed before the loop is declared idle and restarted. A fast-alignment option makes the first transition after an idle spell set the phase directly. A hold input keeps the whole loop cleared for as long as it is high. The `active` output shows that the loop has seen data and has not timed out. It is typically used to qualify the strobes downstream.

Top module: `oversample_cdr`

## Requirements
- R1: While `holdReset` is 1 (and after `rst_n` low), `active` and `bitStrobe` are 0 one cycle later, and the phase and period offset are cleared, so that afterwards the loop runs at exactly the nominal period.
- R2: `bitStrobe` is a single-cycle pulse that occurs only while `active` was 1. With no input transitions, strobes repeat every P cycles, where P is the current recovered period.
- R3: `dataOut` changes only together with a strobe, and it then holds the input level sampled at the mid-bit point.
- R4: With `fastAlign`=1, a transition seen while `active`=0 sets the phase so that the first strobe comes mid+1 cycles after the cycle in which the new level is presented, where mid = floor(P/2).
- R5: With no snap, a transition at a phase below mid holds the phase for one cycle and raises P by 1. A transition at a phase at or above mid advances the phase by two and lowers P by 1. A transition at phase 0 changes nothing.
- R6: The period offset saturates at plus or minus a bound equal to the nominal period shifted right by 3, 4, 5 or 6 for `clampSel` = 00, 01, 10, 11. A bound that comes out as 0 is raised to 1.
- R7: With `actSel` = 01, 10 or 11, after 4, 8 or 16 period wraps with no transition, `active` falls, strobes stop and the period offset returns to 0.
- R8: With `actSel` = 00, `active` never falls without a hold or reset.
- R9: `active` rises one cycle after the first transition seen following reset, hold or timeout.
- R10: A `nomPeriod` value below 2 acts as 2, and one above 400 acts as 400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxBit | input | 1 | Raw serial input, one sample per clock |
| nomPeriod | input | PERIOD_W | Nominal samples per bit (2 to 400) |
| clampSel | input | 2 | Drift clamp selector |
| actSel | input | 2 | Inactivity timeout selector, 00 disables |
| fastAlign | input | 1 | Snap phase on first transition while idle |
| holdReset | input | 1 | Synchronous hold-clear of the loop |
| dataOut | output | 1 | Retimed data bit |
| bitStrobe | output | 1 | One-cycle pulse per recovered bit |
| active | output | 1 | Loop has data and has not timed out |

## Verification
A wrong phase shows up at the first strobe after a transition, as a cycle count that differs from mid+1 (snap) or from the held-phase value (slew). A corrupted period offset shows up as a free-running strobe interval that differs from the nominal period plus the expected clamped offset, within two bit times after the input goes quiet. A bad idle counter moves the falling edge of `active` away from an exact multiple of the period, and that difference is visible at the first timeout.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  // Phase observations the datapath reports to the control
  typedef struct packed {
    logic phaseZero;
    logic phaseLow;
    logic atMid;
    logic atWrap;
  } loopStatus_t;

  // One-cycle commands the control issues to the datapath
  typedef struct packed {
    logic clearAll;
    logic timeout;
    logic snap;
    logic lagStep;
    logic leadStep;
    logic strobe;
  } loopCmd_t;

endpackage

// File: rtl/cdr_ctrl.sv
module cdr_ctrl
  import cdr_pkg::*;
#(
  parameter int ACT_BASE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxBit,
  input  logic        holdReset,
  input  logic        fastAlign,
  input  logic [1:0]  actSel,
  input  loopStatus_t status,
  output loopCmd_t    cmd,
  output logic        rxSample,
  output logic        active
);

  localparam int IDLE_W = $clog2(ACT_BASE * 4) + 1;

  logic              edgeSeen;
  logic [IDLE_W-1:0] idleCnt;
  logic [IDLE_W-1:0] idleLimit;
  logic              checkOn;
  logic              idleDone;

  assign edgeSeen = rxBit ^ rxSample;
  assign checkOn  = (actSel != 2'b00);

  always_comb begin
    idleLimit = IDLE_W'(ACT_BASE) << (actSel - 2'd1);
  end

  assign idleDone = (idleCnt + IDLE_W'(1)) >= idleLimit;

  always_comb begin
    cmd          = '0;
    cmd.clearAll = holdReset;
    if (!holdReset) begin
      cmd.snap   = edgeSeen & fastAlign & ~active;
      cmd.lagStep  = edgeSeen & ~cmd.snap & ~status.phaseZero &  status.phaseLow;
      cmd.leadStep = edgeSeen & ~cmd.snap & ~status.phaseZero & ~status.phaseLow;
      cmd.timeout  = ~edgeSeen & active & status.atWrap & checkOn & idleDone;
      cmd.strobe   = active & status.atMid;
    end
  end

  // Input sample register used for transition detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rxSample <= 1'b0;
    else        rxSample <= rxBit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idleCnt <= '0;
    end else begin
      if (cmd.clearAll)      active <= 1'b0;
      else if (edgeSeen)     active <= 1'b1;
      else if (cmd.timeout)  active <= 1'b0;

      if (cmd.clearAll || edgeSeen || !active || cmd.timeout)
        idleCnt <= '0;
      else if (status.atWrap && idleCnt != '1)
        idleCnt <= idleCnt + IDLE_W'(1);
    end
  end

endmodule

// File: rtl/cdr_datapath.sv
module cdr_datapath
  import cdr_pkg::*;
#(
  parameter int PERIOD_W    = 9,
  parameter int MIN_PERIOD  = 2,
  parameter int MAX_PERIOD  = 400,
  parameter int CLAMP_SHIFT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] nomPeriod,
  input  logic [1:0]          clampSel,
  input  logic                rxSample,
  input  loopCmd_t            cmd,
  output loopStatus_t         status,
  output logic                dataOut,
  output logic                bitStrobe
);

  localparam int OW = PERIOD_W + 1;
  localparam logic [PERIOD_W-1:0] MIN_P = PERIOD_W'(MIN_PERIOD);
  localparam logic [PERIOD_W-1:0] MAX_P = PERIOD_W'(MAX_PERIOD);
  localparam logic signed [OW-1:0] ONE_S = OW'(1);

  logic [PERIOD_W-1:0]   nomEff;
  logic [PERIOD_W-1:0]   rawBound;
  logic signed [OW-1:0]  boundS;
  logic signed [OW-1:0]  negBound;
  logic signed [OW-1:0]  ofs;
  logic signed [OW-1:0]  ofsNext;
  logic [OW-1:0]         periodLen;
  logic [OW-1:0]         mid;
  logic [OW-1:0]         phase;
  logic [OW-1:0]         phaseNext;
  logic [OW-1:0]         phasePlus2;

  // Nominal period limited to the legal range
  always_comb begin
    if (nomPeriod < MIN_P)      nomEff = MIN_P;
    else if (nomPeriod > MAX_P) nomEff = MAX_P;
    else                        nomEff = nomPeriod;
  end

  // Drift window: nominal shifted by base + selector, at least one sample
  assign rawBound = nomEff >> (3'(CLAMP_SHIFT) + {1'b0, clampSel});
  assign boundS   = (rawBound == '0) ? ONE_S : $signed({1'b0, rawBound});
  assign negBound = -boundS;

  assign periodLen = {1'b0, nomEff} + $unsigned(ofs);
  assign mid       = periodLen >> 1;

  assign status.phaseZero = (phase == '0);
  assign status.phaseLow  = (phase < mid);
  assign status.atMid     = (phase == mid);
  assign status.atWrap    = (phase >= periodLen - OW'(1));

  assign phasePlus2 = phase + OW'(2);

  always_comb begin
    if (cmd.clearAll || cmd.timeout)  phaseNext = '0;
    else if (cmd.snap)                phaseNext = OW'(1);
    else if (cmd.lagStep)             phaseNext = phase;
    else if (cmd.leadStep)
      phaseNext = (phasePlus2 >= periodLen) ? phasePlus2 - periodLen : phasePlus2;
    else if (status.atWrap)           phaseNext = '0;
    else                              phaseNext = phase + OW'(1);
  end

  always_comb begin
    ofsNext = ofs;
    if (cmd.clearAll || cmd.timeout) ofsNext = '0;
    else if (cmd.lagStep)  ofsNext = (ofs >= boundS)   ? boundS   : ofs + ONE_S;
    else if (cmd.leadStep) ofsNext = (ofs <= negBound) ? negBound : ofs - ONE_S;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      ofs       <= '0;
      bitStrobe <= 1'b0;
      dataOut   <= 1'b0;
    end else begin
      phase     <= phaseNext;
      ofs       <= ofsNext;
      bitStrobe <= cmd.strobe;
      if (cmd.strobe) dataOut <= rxSample;
    end
  end

endmodule

// File: rtl/oversample_cdr.sv
module oversample_cdr
  import cdr_pkg::*;
#(
  parameter int PERIOD_W    = 9,
  parameter int MIN_PERIOD  = 2,
  parameter int MAX_PERIOD  = 400,
  parameter int CLAMP_SHIFT = 3,
  parameter int ACT_BASE    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rxBit,
  input  logic [PERIOD_W-1:0] nomPeriod,
  input  logic [1:0]          clampSel,
  input  logic [1:0]          actSel,
  input  logic                fastAlign,
  input  logic                holdReset,
  output logic                dataOut,
  output logic                bitStrobe,
  output logic                active
);

  loopStatus_t loopStat;
  loopCmd_t    loopCmd;
  logic        rxSample;

  cdr_ctrl #(
    .ACT_BASE (ACT_BASE)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxBit     (rxBit),
    .holdReset (holdReset),
    .fastAlign (fastAlign),
    .actSel    (actSel),
    .status    (loopStat),
    .cmd       (loopCmd),
    .rxSample  (rxSample),
    .active    (active)
  );

  cdr_datapath #(
    .PERIOD_W    (PERIOD_W),
    .MIN_PERIOD  (MIN_PERIOD),
    .MAX_PERIOD  (MAX_PERIOD),
    .CLAMP_SHIFT (CLAMP_SHIFT)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .nomPeriod (nomPeriod),
    .clampSel  (clampSel),
    .rxSample  (rxSample),
    .cmd       (loopCmd),
    .status    (loopStat),
    .dataOut   (dataOut),
    .bitStrobe (bitStrobe)
  );

endmodule

// File: rtl/oversample_cdr_chk.sv
module oversample_cdr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rxBit,
  input logic       rxSample,
  input logic       holdReset,
  input logic [1:0] actSel,
  input logic       dataOut,
  input logic       bitStrobe,
  input logic       active
);

  p_strobe_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bitStrobe |=> !bitStrobe);

  p_strobe_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bitStrobe |-> $past(active));

  p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    holdReset |=> (!bitStrobe && !active));

  p_data_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dataOut) |-> bitStrobe);

  p_active_rise_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(rxBit != rxSample));

  p_no_timeout_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active) && !$past(holdReset)) |-> ($past(actSel) != 2'b00));

endmodule

bind oversample_cdr oversample_cdr_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rxBit     (rxBit),
  .rxSample  (rxSample),
  .holdReset (holdReset),
  .actSel    (actSel),
  .dataOut   (dataOut),
  .bitStrobe (bitStrobe),
  .active    (active)
);

// File: tb/oversample_cdr_tb_top.sv
`timescale 1ns/1ps
module oversample_cdr_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxBit = 1'b0;
  logic [8:0] nomPeriod = 9'd64;
  logic [1:0] clampSel = 2'b00;
  logic [1:0] actSel = 2'b00;
  logic       fastAlign = 1'b0;
  logic       holdReset = 1'b0;
  logic       dataOut, bitStrobe, active;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic rxLevel = 1'b0;

  always #4 clk = ~clk;

  oversample_cdr dut_i (
    .clk(clk), .rst_n(rst_n), .rxBit(rxBit), .nomPeriod(nomPeriod),
    .clampSel(clampSel), .actSel(actSel), .fastAlign(fastAlign),
    .holdReset(holdReset), .dataOut(dataOut), .bitStrobe(bitStrobe),
    .active(active)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic toggleRx();
    rxLevel = ~rxLevel;
    rxBit   = rxLevel;
  endtask

  task automatic countToStrobe(output int n, input int limit);
    n = 0;
    do begin
      cyc();
      n++;
    end while (!bitStrobe && n < limit);
  endtask

  task automatic restart(input int nom, input int cs, input int as, input bit fa);
    nomPeriod = 9'(nom);
    clampSel  = 2'(cs);
    actSel    = 2'(as);
    fastAlign = fa;
    rxLevel   = 1'b0;
    rxBit     = 1'b0;
    holdReset = 1'b1;
    cyc();
    holdReset = 1'b0;
  endtask

  task automatic leadEdges(input int k);
    int n;
    for (int i = 0; i < k; i++) begin
      countToStrobe(n, 1000);
      toggleRx();
    end
  endtask

  task automatic test_reset();
    chk("R1 reset active", int'(active), 0);
    chk("R1 reset strobe", int'(bitStrobe), 0);
    chk("R1 reset dataOut", int'(dataOut), 0);
  endtask

  task automatic test_fast_align();
    int n, seen;
    restart(64, 0, 0, 1);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      cyc();
      if (bitStrobe || active) seen++;
    end
    chk("R2 no strobe while idle", seen, 0);
    toggleRx();
    cyc();
    chk("R9 active after first edge", int'(active), 1);
    countToStrobe(n, 1000);
    chk("R4 snap strobe delay", n + 1, 33);
    chk("R3 captured level", int'(dataOut), 1);
  endtask

  task automatic test_slew();
    int n;
    restart(64, 0, 0, 0);
    repeat (10) cyc();
    toggleRx();
    countToStrobe(n, 1000);
    chk("R5 lag hold first strobe", n, 24);
    countToStrobe(n, 1000);
    chk("R5 lag raises period", n, 65);
  endtask

  task automatic test_clamp(input int nom, input int cs, input int exp);
    int n;
    restart(nom, cs, 0, 1);
    toggleRx();
    leadEdges(12);
    countToStrobe(n, 1000);
    countToStrobe(n, 1000);
    chk($sformatf("R6 clamp code %0d nom %0d", cs, nom), n, exp);
  endtask

  task automatic test_nominal_limits();
    int n;
    restart(1, 0, 0, 1);
    toggleRx();
    countToStrobe(n, 1000);
    countToStrobe(n, 1000);
    chk("R10 low limit period", n, 2);
    restart(500, 0, 0, 1);
    toggleRx();
    countToStrobe(n, 1000);
    countToStrobe(n, 1000);
    chk("R10 high limit period", n, 400);
  endtask

  task automatic test_timeout(input int code, input int bits);
    int n, strobes, late;
    restart(64, 0, code, 1);
    toggleRx();
    n = 0;
    strobes = 0;
    while (n < 3000) begin
      cyc();
      n++;
      if (bitStrobe) strobes++;
      if (!active) break;
    end
    chk($sformatf("R7 timeout cycles code %0d", code), n, 64 * bits);
    chk($sformatf("R7 strobes before timeout code %0d", code), strobes, bits);
    late = 0;
    for (int i = 0; i < 200; i++) begin
      cyc();
      if (bitStrobe) late++;
    end
    chk("R7 no strobe after timeout", late, 0);
  endtask

  task automatic test_no_timeout();
    int strobes;
    restart(64, 0, 0, 1);
    toggleRx();
    strobes = 0;
    for (int i = 0; i < 1200; i++) begin
      cyc();
      if (bitStrobe) strobes++;
    end
    chk("R8 still active", int'(active), 1);
    chk("R8 strobes keep running", strobes, 19);
  endtask

  task automatic test_timeout_restore();
    int n;
    restart(64, 0, 1, 1);
    toggleRx();
    leadEdges(3);
    n = 0;
    while (active && n < 3000) begin
      cyc();
      n++;
    end
    chk("R7 timed out", int'(active), 0);
    toggleRx();
    countToStrobe(n, 1000);
    countToStrobe(n, 1000);
    chk("R7 period back to nominal", n, 64);
  endtask

  task automatic test_hold();
    int n, bad;
    restart(64, 0, 0, 1);
    toggleRx();
    leadEdges(3);
    holdReset = 1'b1;
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      cyc();
      if (active || bitStrobe) bad++;
    end
    chk("R1 quiet while held", bad, 0);
    holdReset = 1'b0;
    toggleRx();
    countToStrobe(n, 1000);
    chk("R1 fresh phase after hold", n, 33);
    countToStrobe(n, 1000);
    chk("R1 nominal period after hold", n, 64);
  endtask

  task automatic test_data();
    logic [15:0] pattern;
    int cnt, bad, miss;
    pattern = 16'b1011_0010_1110_0100;
    restart(16, 0, 0, 1);
    bad = 0;
    miss = 0;
    for (int b = 15; b >= 0; b--) begin
      rxLevel = pattern[b];
      rxBit   = rxLevel;
      cnt = 0;
      for (int i = 0; i < 16; i++) begin
        cyc();
        if (bitStrobe) begin
          cnt++;
          if (dataOut != pattern[b]) bad++;
        end
      end
      if (cnt != 1) miss++;
    end
    chk("R3 data mismatches", bad, 0);
    chk("R2 one strobe per bit", miss, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    cyc();
    test_fast_align();
    test_slew();
    test_clamp(64, 0, 56);
    test_clamp(64, 1, 60);
    test_clamp(64, 2, 62);
    test_clamp(40, 3, 39);
    test_nominal_limits();
    test_timeout(1, 4);
    test_timeout(2, 8);
    test_timeout(3, 16);
    test_no_timeout();
    test_timeout_restore();
    test_hold();
    test_data();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule